// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels owns a shared system bus. When any channel asks for service it requests the bus from an external bus master. Once the master acknowledges, the block grants the bus to exactly one channel. After every completed transfer, signalled by a one-cycle done strobe, it chooses one of three actions: keep the current owner, hand the bus to another channel, or give the bus back to the master.

A byte-wide control register, written and read through a simple register port, holds three policy fields. The first is a three-bit priority-mode field that selects one of four rotated fixed orders or a round-robin order. The second is a release-policy bit that chooses between holding the bus until no requests remain and granting each channel one transfer per tenure. The third is a switch-policy bit that either re-arbitrates after every transfer or keeps the current owner for as long as it keeps requesting. Data movers, address counters and descriptor handling sit outside this block.

Top module: `dma_bus_arbiter`

## Requirements
- R1: During and right after reset, grant is 0, bus_req is 0 and reg_rdata reads 0x00; the last-granted pointer used by round-robin resets to channel 3.
- R2: A register write stores wdata[4:0]. reg_rdata always returns {3'b000, stored[4:0]}, so bits 7:5 read as zero whatever was written. Field layout: bit 4 is the release policy, bit 3 is the switch policy, bits 2:0 are the priority mode.
- R3: bus_req rises in the cycle after a request is seen while idle. A grant is issued only at an edge where bus_ack is sampled high, and it appears in the cycle after that edge. If no request remains at that edge, the bus is returned without a grant.
- R4: Priority modes 000, 001, 010 and 011 pick the lowest-numbered requesting channel counting upward from channel 0, 1, 2 and 3 respectively, wrapping from 3 to 0.
- R5: Priority mode 100 is round-robin. The search starts at the channel after the last granted one, wrapping from 3 to 0.
- R6: grant is one-hot or zero. While the bus is held, it changes only in the cycle after a sampled xfer_done. xfer_done is ignored when no channel holds a grant.
- R7: With bit 4 clear, a transfer completion with no channel requesting returns the bus. grant and bus_req are both 0 in the following cycle.
- R8: With bit 4 set, each completion marks the current owner as served, and the next owner is picked among requesting channels not yet served. When none is left, the bus is returned. The served set clears whenever the bus is returned.
- R9: With bit 4 clear and bit 3 set, the owner keeps the bus after a completion while its own request is still high. With bit 3 clear, every completion re-arbitrates among all requesters, the owner included.
- R10: After the bus is returned, bus_req stays low for at least one cycle, and no grant is present in a cycle where bus_req has just risen.
- R11: Priority mode values 101, 110 and 111 behave exactly like 000.
- R12: A register write takes effect at the next arbitration decision. A decision made at the same clock edge as a write uses the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Per-channel transfer request |
| grant | output | 4 | One-hot bus ownership, registered |
| xfer_done | input | 1 | One-cycle strobe marking the end of the owner's transfer |
| bus_req | output | 1 | Request for the bus to the external master |
| bus_ack | input | 1 | Bus granted by the external master |
| reg_wr | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |

## Verification
The assertions take for granted that the external master keeps bus_ack high for as long as bus_req stays high after it has acknowledged, and lowers it only once bus_req has dropped. They also assume xfer_done describes a transfer by the current owner. The stimulus plays the master by raising bus_ack a random number of cycles after bus_req and clearing it as soon as bus_req is low. Requests toggle at random, and done strobes are also issued while no grant exists so that the ignore rule is exercised. Occasional writes carrying random reserved bits and out-of-range priority codes land in the middle of a tenure.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
    localparam int NCH = 4;
    localparam int CW  = $clog2(NCH);
    localparam int CFG_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic       rel_each;  // bit 4: one transfer per channel per tenure
        logic       sticky;    // bit 3: owner keeps bus while requesting
        logic [2:0] mode;      // bits 2:0: priority mode
    } arb_cfg_t;

    localparam logic [2:0] MODE_RR = 3'b100;

    // channel at which the priority search starts
    function automatic logic [CW-1:0] search_start(input logic [2:0] mode,
                                                   input logic [CW-1:0] last);
        if (mode[2] == 1'b0)
            return CW'(mode[1:0]);
        else if (mode == MODE_RR)
            return last + CW'(1);
        else
            return '0;
    endfunction
endpackage

// File: rtl/dma_arb_cfg_reg.sv
`timescale 1ns/1ps
module dma_arb_cfg_reg
    import dma_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output arb_cfg_t   cfg,
    output logic [7:0] rdata
);
    arb_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= arb_cfg_t'(wdata[CFG_W-1:0]);
    end

    assign cfg   = cfg_q;
    assign rdata = {{(8-CFG_W){1'b0}}, cfg_q};
endmodule

// File: rtl/dma_arb_pick.sv
`timescale 1ns/1ps
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int N  = NCH,
    parameter int IW = $clog2(N)
)(
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    // search from start upward; lower offsets overwrite higher ones
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            logic [IW-1:0] c;
            c = IW'((int'(start) + k) % N);
            if (mask[c]) begin
                found = 1'b1;
                idx   = c;
            end
        end
    end
endmodule

// File: rtl/dma_bus_arbiter.sv
`timescale 1ns/1ps
module dma_bus_arbiter
    import dma_arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] grant,
    input  logic           xfer_done,
    output logic           bus_req,
    input  logic           bus_ack,
    input  logic           reg_wr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata
);
    arb_cfg_t       cfg;
    arb_state_e     state_q;
    logic [NCH-1:0] grant_q;
    logic [NCH-1:0] served_q;
    logic [CW-1:0]  last_q;

    logic [NCH-1:0] served_nx;
    logic [NCH-1:0] cand;
    logic [CW-1:0]  start;
    logic           win_found;
    logic [CW-1:0]  win_idx;
    logic           keep_owner;

    dma_arb_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .wdata (reg_wdata),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    assign served_nx  = served_q | grant_q;
    assign keep_owner = !cfg.rel_each && cfg.sticky && (|(req & grant_q));
    assign start      = search_start(cfg.mode, last_q);

    always_comb begin
        if (state_q == ST_OWN && cfg.rel_each)
            cand = req & ~served_nx;
        else
            cand = req;
    end

    dma_arb_pick #(.N(NCH)) u_pick (
        .mask  (cand),
        .start (start),
        .found (win_found),
        .idx   (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            grant_q  <= '0;
            served_q <= '0;
            last_q   <= CW'(NCH - 1);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (|req) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (bus_ack) begin
                        if (win_found) begin
                            grant_q <= NCH'(1) << win_idx;
                            last_q  <= win_idx;
                            state_q <= ST_OWN;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_OWN: begin
                    if (xfer_done) begin
                        served_q <= served_nx;
                        if (keep_owner) begin
                            grant_q <= grant_q;
                        end else if (win_found) begin
                            grant_q <= NCH'(1) << win_idx;
                            last_q  <= win_idx;
                        end else begin
                            grant_q  <= '0;
                            served_q <= '0;
                            state_q  <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign grant   = grant_q;
    assign bus_req = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
`timescale 1ns/1ps
module dma_bus_arbiter_chk
    import dma_arb_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] req,
    input logic [NCH-1:0] grant,
    input logic           xfer_done,
    input logic           bus_req,
    input logic           bus_ack,
    input logic [7:0]     reg_rdata
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R6

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (|grant && !xfer_done) |=> $stable(grant)); // R6

    AST_GRANT_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> (bus_ack && bus_req)); // R3

    AST_NO_GRANT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> (grant == '0)); // R10

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7:5] == 3'b000); // R2

    AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (|grant && xfer_done && req == '0) |=> (grant == '0 && !bus_req)); // R7

    AST_EACH_MOVES_ON: assert property (@(posedge clk) disable iff (rst)
        (|grant && xfer_done && reg_rdata[4]) |=> (grant != $past(grant))); // R8

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (|grant && xfer_done && !reg_rdata[4] && reg_rdata[3] && |(req & grant))
        |=> $stable(grant)); // R9
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .grant     (grant),
    .xfer_done (xfer_done),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .reg_rdata (reg_rdata)
);

// File: tb/dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module dma_bus_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = '0;
    logic [3:0] grant;
    logic       xfer_done = 1'b0;
    logic       bus_req;
    logic       bus_ack = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model state
    int       m_state;   // 0 idle, 1 waiting for ack, 2 owning
    int       m_gnt;     // -1 when none
    bit [3:0] m_served;
    int       m_last;
    bit [4:0] m_cfg;

    always #2.5 clk = ~clk;

    dma_bus_arbiter uut (
        .clk(clk), .rst(rst), .req(req), .grant(grant), .xfer_done(xfer_done),
        .bus_req(bus_req), .bus_ack(bus_ack), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pick(bit [3:0] m, int mode, int last);
        int s;
        if (mode < 4)       s = mode;
        else if (mode == 4) s = (last + 1) % 4;
        else                s = 0;
        for (int k = 0; k < 4; k++) begin
            if (m[(s + k) % 4]) return (s + k) % 4;
        end
        return -1;
    endfunction

    function automatic string mode_tag();
        if (m_cfg[4])            return "R8";
        if (m_cfg[3])            return "R9";
        if (m_cfg[2:0] == 3'd4)  return "R5";
        if (m_cfg[2:0] > 3'd4)   return "R11";
        return "R4 R7";
    endfunction

    function automatic bit [3:0] exp_grant();
        return (m_gnt < 0) ? 4'b0 : 4'(1 << m_gnt);
    endfunction

    // compare outputs with the model, away from the clock edge
    task automatic compare();
        check(grant == exp_grant(), {mode_tag(), " R6 grant"}, grant, exp_grant());
        check(bus_req == (m_state != 0), "R3 R10 bus_req", bus_req, m_state != 0);
        check(reg_rdata == {3'b000, m_cfg}, "R2 R12 rdata", reg_rdata, {3'b000, m_cfg});
        if (grant != 0) check(bus_ack == 1'b1, "R3 ack", bus_ack, 1);
    endtask

    // model advance for one clock edge with the inputs about to be sampled
    task automatic model_step();
        bit [3:0] cand;
        int       w;
        bit [4:0] cfg_used = m_cfg;   // decision uses pre-write value (R12)
        if (reg_wr) m_cfg = reg_wdata[4:0];
        case (m_state)
            0: if (req != 0) m_state = 1;
            1: if (bus_ack) begin
                   w = pick(req, cfg_used[2:0], m_last);
                   if (w >= 0) begin m_gnt = w; m_last = w; m_state = 2; end
                   else m_state = 0;
               end
            default: if (xfer_done) begin
                   bit [3:0] sv = m_served;
                   sv[m_gnt] = 1'b1;
                   m_served = sv;
                   if (!cfg_used[4] && cfg_used[3] && req[m_gnt]) begin
                       // owner keeps the bus
                   end else begin
                       cand = cfg_used[4] ? (req & ~sv) : req;
                       w = pick(cand, cfg_used[2:0], m_last);
                       if (w >= 0) begin m_gnt = w; m_last = w; end
                       else begin m_gnt = -1; m_served = '0; m_state = 0; end
                   end
               end
        endcase
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run_phase(input bit [7:0] cfgv, input int n);
        reg_wr = 1'b1; reg_wdata = cfgv; xfer_done = 1'b0;
        cycle();
        for (int i = 0; i < n; i++) begin
            reg_wr = ($urandom % 50) == 0;
            reg_wdata = 8'($urandom);
            for (int b = 0; b < 4; b++) if ($urandom % 5 == 0) req[b] = ~req[b];
            if (!bus_req)                   bus_ack = 1'b0;
            else if ($urandom % 2 == 0)     bus_ack = 1'b1;
            // done pulses also while no grant, to show they are ignored (R6)
            xfer_done = (grant != 0) ? (($urandom % 5) < 2) : (($urandom % 8) == 0);
            cycle();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_state = 0; m_gnt = -1; m_served = '0; m_last = 3; m_cfg = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(grant == 4'b0, "R1 grant", grant, 0);
        check(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
        check(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);

        // R2 reserved bits dropped
        reg_wr = 1'b1; reg_wdata = 8'hFF;
        cycle();
        check(reg_rdata == 8'h1F, "R2 reserved", reg_rdata, 8'h1F);
        reg_wr = 1'b1; reg_wdata = 8'h00;
        cycle();
        reg_wr = 1'b0;

        // R3 / R4 directed: two requests, ack after a delay, fixed order mode 000
        req = 4'b1010;
        cycle();
        check(bus_req == 1'b1 && grant == 4'b0, "R3 request raised", {bus_req, grant}, 5'b10000);
        cycle();
        check(grant == 4'b0, "R3 no grant without ack", grant, 0);
        bus_ack = 1'b1;
        cycle();
        check(grant == 4'b0010, "R4 lowest from 0", grant, 4'b0010);
        // R7: done with requests gone returns the bus
        req = 4'b0000; xfer_done = 1'b1;
        cycle();
        xfer_done = 1'b0;
        check(grant == 4'b0 && bus_req == 1'b0, "R7 release", {bus_req, grant}, 0);
        bus_ack = 1'b0;
        cycle();
        check(bus_req == 1'b0, "R10 gap", bus_req, 0);

        run_phase(8'h00, 400);
        run_phase(8'h01, 400);
        run_phase(8'h02, 400);
        run_phase(8'h03, 400);
        run_phase(8'h04, 400);
        run_phase(8'h05, 300);
        run_phase(8'hE7, 300);
        run_phase(8'h08, 400);
        run_phase(8'h0C, 400);
        run_phase(8'h10, 400);
        run_phase(8'h14, 400);
        run_phase(8'h18, 400);
        run_phase(8'h1B, 400);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule